// File: doc/BRIEF.md
# Multiplexed Host Bus Front End

This block connects a host to a two-channel serial controller over one shared 8-bit address/data bus. The host frames each transaction with a latch strobe. While that strobe is low, the byte on the bus is taken as a register address. While it is high, active-low read and write strobes move data, but only when an active-low select is asserted. Bit 6 of the captured address chooses the channel, and the low six bits give the register index. Each channel sees a simple register port made of one read pulse, one write pulse, an index, write data and returned read data.

All host inputs arrive without a clock relation. Two flip-flops bring each one into the internal clock domain before any edge is detected, so every strobe edge yields exactly one pulse. A low-power input stops all access and releases the bus. When that input is released, the block resets its own state and gives the channels a one-cycle reset pulse.

Top module: `hostbus_mux`

## Requirements
- R1: After reset, `bus_oe`, `ch_rd`, `ch_wr` and `ch_rst` are all 0.
- R2: While `latch_n` is low, the bus byte is captured as the address. `ch_idx` is its bits 5:0, and bit 7 has no effect on index or channel.
- R3: Address bit 6 picks the channel: 0 targets channel A (`ch_rd[0]`/`ch_wr[0]`) and 1 targets channel B (bit 1).
- R4: A falling edge of `rd_n` in the data phase with `sel_n` low produces exactly one single-cycle pulse on the selected `ch_rd` bit.
- R5: One clock after the read pulse, the selected channel's read data is captured. It is driven on `bus_out` while `bus_oe` is 1, and `bus_oe` is 1 only while `sel_n` and `rd_n` are low in the data phase. The value holds until `rd_n` rises.
- R6: A write produces no pulse on the falling edge of `wr_n`. It produces exactly one single-cycle `ch_wr` pulse after the rising edge, carrying the bus value present at that edge on `ch_wdata`.
- R7: While `sel_n` is high, read and write strobes produce no pulses and `bus_oe` stays 0.
- R8: While `lowpwr` is high, no read or write pulses occur and `bus_oe` stays 0.
- R9: A falling edge of `lowpwr` gives one single-cycle `ch_rst` pulse and clears the address latch, so a following data-phase read goes to channel A, index 0.
- R10: Read or write strobe edges while `latch_n` is low produce no channel pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lowpwr | input | 1 | Low-power request, active high |
| latch_n | input | 1 | Address phase when low, data phase when high |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Shared address/data bus, input side |
| bus_out | output | 8 | Shared bus, output side |
| bus_oe | output | 1 | Bus output enable |
| ch_rd | output | 2 | Read pulse per channel (bit 0 = A) |
| ch_wr | output | 2 | Write pulse per channel (bit 0 = A) |
| ch_idx | output | 6 | Register index to the channels |
| ch_wdata | output | 8 | Write data to the channels |
| ch_rdata_a | input | 8 | Read data from channel A |
| ch_rdata_b | input | 8 | Read data from channel B |
| ch_rst | output | 1 | One-cycle reset pulse to the channels |

## Verification
The assertions assume the host keeps each strobe level for at least three clocks, so the two-flop synchronizers never miss an edge. They also assume the bus byte stays steady across address capture and across the rising edge of the write strobe. The bench changes inputs only on falling clock edges and holds every level for four or more cycles. It keeps `latch_n`, `sel_n` and `lowpwr` stable while a read or write strobe is low, except in the cases that test these inputs on purpose.

// File: rtl/hostbus_mux.sv
module hostbus_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lowpwr,
  input  logic       latch_n,
  input  logic       sel_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic [1:0] ch_rd,
  output logic [1:0] ch_wr,
  output logic [5:0] ch_idx,
  output logic [7:0] ch_wdata,
  input  logic [7:0] ch_rdata_a,
  input  logic [7:0] ch_rdata_b,
  output logic       ch_rst
);

  logic [4:0] s1, s2;
  logic [7:0] d1, d2;
  logic       rd_q, wr_q, lp_q;
  logic [7:0] addr;
  logic [7:0] rdata;
  logic       rd_pend, wr_arm;

  wire ale_s = s2[0];
  wire cs_s  = s2[1];
  wire rd_s  = s2[2];
  wire wr_s  = s2[3];
  wire lp_s  = s2[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 5'b01111;
      s2 <= 5'b01111;
      d1 <= '0;
      d2 <= '0;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      lp_q <= 1'b0;
    end else begin
      s1 <= {lowpwr, wr_n, rd_n, sel_n, latch_n};
      s2 <= s1;
      d1 <= bus_in;
      d2 <= d1;
      rd_q <= rd_s;
      wr_q <= wr_s;
      lp_q <= lp_s;
    end
  end

  wire lp_fall   = lp_q & ~lp_s;
  wire access_ok = ale_s & ~cs_s & ~lp_s;
  wire rd_go     = rd_q & ~rd_s & access_ok;
  wire wr_fall   = wr_q & ~wr_s & access_ok;
  wire wr_go     = ~wr_q & wr_s & access_ok & wr_arm;
  wire chan      = addr[6];

  assign ch_rd    = rd_go ? (chan ? 2'b10 : 2'b01) : 2'b00;
  assign ch_wr    = wr_go ? (chan ? 2'b10 : 2'b01) : 2'b00;
  assign ch_idx   = addr[5:0];
  assign ch_wdata = d2;
  assign ch_rst   = lp_fall;
  assign bus_oe   = access_ok & ~rd_s;
  assign bus_out  = rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      rdata <= '0;
      rd_pend <= 1'b0;
      wr_arm <= 1'b0;
    end else if (lp_fall) begin
      addr <= '0;
      rdata <= '0;
      rd_pend <= 1'b0;
      wr_arm <= 1'b0;
    end else begin
      if (!ale_s && !lp_s) addr <= d2;
      rd_pend <= rd_go;
      if (rd_pend) rdata <= chan ? ch_rdata_b : ch_rdata_a;
      if (!access_ok) wr_arm <= 1'b0;
      else if (wr_fall) wr_arm <= 1'b1;
      else if (wr_go) wr_arm <= 1'b0;
    end
  end

  AST_RD_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_rd)); // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (|ch_rd) |=> (ch_rd == 2'b00)); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (|ch_wr) |=> (ch_wr == 2'b00)); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !((|ch_rd) && (|ch_wr))); // R6
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_oe && $past(bus_oe) && !$past(rd_pend)) |-> $stable(bus_out)); // R5
  AST_NO_ACCESS_LP: assert property (@(posedge clk) disable iff (!rst_n) lp_s |-> (ch_rd == 2'b00 && ch_wr == 2'b00 && !bus_oe)); // R8
  AST_NO_ACCESS_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_s |-> (ch_rd == 2'b00 && ch_wr == 2'b00 && !bus_oe)); // R7
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ch_rst |=> !ch_rst); // R9
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ch_rst |=> (ch_idx == 6'd0)); // R9

endmodule

// File: tb/hostbus_mux_test.sv
module hostbus_mux_test;
  logic clk = 0, rst_n = 0;
  logic lowpwr = 0, latch_n = 1, sel_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] bus_in = 0;
  logic [7:0] bus_out, ch_wdata, rda, rdb;
  logic bus_oe, ch_rst;
  logic [1:0] ch_rd, ch_wr;
  logic [5:0] ch_idx;

  int tests = 0, fails = 0;
  int n_rda = 0, n_rdb = 0, n_wra = 0, n_wrb = 0, n_rst = 0;
  logic [7:0] last_wd;
  logic [5:0] last_idx;

  always #10 clk = ~clk;

  function automatic logic [7:0] rfun(input bit b, input logic [5:0] i);
    return b ? 8'((i * 5 + 7) & 8'hFF) : ({2'b00, i} ^ 8'h3C);
  endfunction

  assign rda = rfun(1'b0, ch_idx);
  assign rdb = rfun(1'b1, ch_idx);

  hostbus_mux uut (.clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .latch_n(latch_n),
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .ch_rd(ch_rd), .ch_wr(ch_wr), .ch_idx(ch_idx),
    .ch_wdata(ch_wdata), .ch_rdata_a(rda), .ch_rdata_b(rdb), .ch_rst(ch_rst));

  always @(posedge clk) begin
    if (ch_rd[0]) n_rda++;
    if (ch_rd[1]) n_rdb++;
    if (ch_wr[0]) n_wra++;
    if (ch_wr[1]) n_wrb++;
    if (ch_rst) n_rst++;
    if (|ch_rd || |ch_wr) last_idx = ch_idx;
    if (|ch_wr) last_wd = ch_wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    latch_n = 0; bus_in = a; cyc(4);
    latch_n = 1; cyc(3);
  endtask

  task automatic do_read(input bit b, input logic [5:0] i);
    int a0 = n_rda, b0 = n_rdb;
    sel_n = 0; cyc(1);
    rd_n = 0; cyc(6);
    chk("R5 oe", bus_oe, 1);
    chk("R5 data", bus_out, rfun(b, i));
    cyc(3);
    chk("R5 hold", bus_out, rfun(b, i));
    rd_n = 1; cyc(4);
    chk("R5 release", bus_oe, 0);
    chk("R4 R3 pulses A", n_rda - a0, b ? 0 : 1);
    chk("R4 R3 pulses B", n_rdb - b0, b ? 1 : 0);
    chk("R2 index", last_idx, i);
    sel_n = 1; cyc(1);
  endtask

  task automatic do_write(input bit b, input logic [5:0] i, input logic [7:0] d);
    int a0 = n_wra, b0 = n_wrb;
    sel_n = 0; cyc(1);
    bus_in = d; wr_n = 0; cyc(5);
    chk("R6 none on fall", (n_wra - a0) + (n_wrb - b0), 0);
    wr_n = 1; cyc(5);
    chk("R6 R3 pulses A", n_wra - a0, b ? 0 : 1);
    chk("R6 R3 pulses B", n_wrb - b0, b ? 1 : 0);
    chk("R6 data", last_wd, d);
    chk("R2 index", last_idx, i);
    sel_n = 1; cyc(1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s;
    cyc(3);
    chk("R1 oe", bus_oe, 0);
    chk("R1 pulses", {ch_rd, ch_wr, ch_rst}, 0);
    rst_n = 1; cyc(3);
    chk("R1 after release", {bus_oe, ch_rd, ch_wr, ch_rst}, 0);

    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) begin
        addr_phase({1'(i % 2), 1'(b), 6'(i)});
        do_read(1'(b), 6'(i));
        do_write(1'(b), 6'(i), 8'((i * 37 + b * 91) & 8'hFF));
      end

    // R7: deselected strobes
    addr_phase(8'h45);
    s = n_rda + n_rdb + n_wra + n_wrb;
    rd_n = 0; cyc(6);
    chk("R7 oe", bus_oe, 0);
    rd_n = 1; cyc(4);
    wr_n = 0; bus_in = 8'h5A; cyc(4); wr_n = 1; cyc(5);
    chk("R7 pulses", n_rda + n_rdb + n_wra + n_wrb - s, 0);

    // R10: strobes in address phase
    latch_n = 0; bus_in = 8'h07; sel_n = 0; cyc(4);
    s = n_rda + n_rdb + n_wra + n_wrb;
    rd_n = 0; cyc(5); rd_n = 1; cyc(4);
    wr_n = 0; cyc(4); wr_n = 1; cyc(5);
    chk("R10 pulses", n_rda + n_rdb + n_wra + n_wrb - s, 0);
    chk("R10 oe", bus_oe, 0);
    sel_n = 1; latch_n = 1; cyc(3);

    // R8 / R9: low power
    addr_phase(8'h4B);
    s = n_rda + n_rdb + n_wra + n_wrb;
    lowpwr = 1; cyc(4);
    chk("R9 no early reset", n_rst, 0);
    sel_n = 0; rd_n = 0; cyc(6);
    chk("R8 oe", bus_oe, 0);
    rd_n = 1; cyc(4);
    wr_n = 0; cyc(4); wr_n = 1; cyc(5);
    chk("R8 pulses", n_rda + n_rdb + n_wra + n_wrb - s, 0);
    sel_n = 1; cyc(2);
    lowpwr = 0; cyc(6);
    chk("R9 reset pulse", n_rst, 1);
    chk("R9 index cleared", ch_idx, 0);
    do_read(1'b0, 6'd0);
    chk("R9 single reset", n_rst, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule